// File: doc/BRIEF.md
# Programmable Host Watchdog Timer

This block supervises a host controller that is expected to toggle a watchdog line at regular intervals. Each high-to-low transition on that line restarts a millisecond countdown. If the host stays silent for longer than the selected window, the block raises a reset/disable signal that forces every power output of the surrounding driver off. The signal stays raised until the host sends a fresh falling edge; no amount of waiting releases it.

The watchdog only operates while the driver is in serial control mode. A two-bit window select chooses between switching the watchdog off and windows of 40, 80 or 160 milliseconds. A prescaler turns the system clock into a one-millisecond timebase, with the number of clock cycles per millisecond set by a parameter. The host line is asynchronous and passes through a two-stage synchroniser before edge detection.

Top module: `host_watchdog`

## Requirements
- R1: After reset, `outputs_off` is 0.
- R2: While `serial_mode` is 0 the watchdog never trips, and dropping `serial_mode` while tripped clears `outputs_off` at the next clock edge.
- R3: A window select of 2'b00 disables the watchdog; `outputs_off` stays 0 however long the host is silent.
- R4: Window select 2'b01, 2'b10 and 2'b11 give windows of 40, 80 and 160 ms; `outputs_off` rises exactly window × TICKS_PER_MS clock cycles after the edge at which the counter was last restarted.
- R5: A falling edge on `wd_n`, seen through the two-stage synchroniser, restarts the full window two clock edges after it is first sampled; periodic edges spaced less than the window keep `outputs_off` at 0.
- R6: Holding `wd_n` low does not hold the counter cleared, and a rising edge on `wd_n` neither restarts the counter nor releases a trip.
- R7: Once tripped, `outputs_off` stays 1 until a falling edge on `wd_n`, which clears it at the same edge that restarts the counter.
- R8: Changing the window select restarts the counter at the next clock edge, and the new window is counted from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_mode | input | 1 | 1 when the driver is under serial control; enables the watchdog |
| tmo_sel | input | 2 | Window select: 00 off, 01 40 ms, 10 80 ms, 11 160 ms |
| wd_n | input | 1 | Asynchronous host kick line; falling edges restart the window |
| outputs_off | output | 1 | 1 forces all driver outputs off after an expiry |

## Verification
The bench goes after the exact expiry cycle for each window, where an off-by-one in the prescaler or millisecond counter would trip one cycle early or late. It holds the kick line low across a full window, which a level-sensitive clear would mistake for continuous kicking and never trip, and releases it afterwards, which a design that reacts to any edge would take as a recovery. It changes the window mid-count, where a design that keeps the old count would trip early, and it drops serial mode or selects the off setting, where a watchdog that ignored them would still cut the outputs.

// File: rtl/host_watchdog.sv
module host_watchdog #(
  parameter int TICKS_PER_MS = 100000,
  parameter int BASE_MS      = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       serial_mode,
  input  logic [1:0] tmo_sel,
  input  logic       wd_n,
  output logic       outputs_off
);
  localparam int PRE_W = $clog2(TICKS_PER_MS + 1);
  localparam int MS_W  = $clog2(4 * BASE_MS + 1);

  logic [2:0]       wd_sync;
  logic [PRE_W-1:0] pre;
  logic [MS_W-1:0]  ms;
  logic [MS_W-1:0]  limit;
  logic [1:0]       sel_q;
  logic             tripped;

  wire fall    = wd_sync[2] & ~wd_sync[1];
  wire active  = serial_mode & (|tmo_sel);
  wire restart = fall | (tmo_sel != sel_q) | ~active;
  wire tick    = (pre == PRE_W'(TICKS_PER_MS - 1));

  always_comb begin
    case (tmo_sel)
      2'b01:   limit = MS_W'(BASE_MS);
      2'b10:   limit = MS_W'(2 * BASE_MS);
      2'b11:   limit = MS_W'(4 * BASE_MS);
      default: limit = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_sync <= 3'b111;
    else        wd_sync <= {wd_sync[1:0], wd_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      ms      <= '0;
      sel_q   <= 2'b00;
      tripped <= 1'b0;
    end else begin
      sel_q <= tmo_sel;
      if (restart) begin
        pre <= '0;
        ms  <= '0;
        if (fall || !active) tripped <= 1'b0;
      end else if (!tripped) begin
        if (tick) begin
          pre <= '0;
          if (ms == limit - MS_W'(1)) begin
            ms      <= '0;
            tripped <= 1'b1;
          end else begin
            ms <= ms + MS_W'(1);
          end
        end else begin
          pre <= pre + PRE_W'(1);
        end
      end
    end
  end

  assign outputs_off = tripped;

  assert_trip_needs_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outputs_off) |-> $past(active));
  assert_inactive_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !outputs_off);
  assert_fall_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !outputs_off);
  assert_ms_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tmo_sel == sel_q) |-> (ms < limit));
  assert_sel_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tmo_sel != sel_q) |=> (ms == '0 && pre == '0));
endmodule

// File: tb/host_watchdog_tb.sv
`timescale 1ns/1ps
module host_watchdog_tb;
  localparam int TPM  = 4;
  localparam int BASE = 40;

  logic clk = 1'b0, rst_n = 1'b0, serial_mode = 1'b1, wd_n = 1'b1;
  logic [1:0] tmo_sel = 2'b00;
  logic outputs_off;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  host_watchdog #(.TICKS_PER_MS(TPM), .BASE_MS(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode),
    .tmo_sel(tmo_sel), .wd_n(wd_n), .outputs_off(outputs_off));

  function automatic int window_cycles(input logic [1:0] s);
    return (BASE << (s - 1)) * TPM;
  endfunction

  task automatic check(input logic exp, input string req);
    total++;
    if (outputs_off !== exp) begin
      bad++;
      $display("FAIL %s outputs_off=%0b expected=%0b t=%0t", req, outputs_off, exp, $time);
    end
  endtask

  task automatic wait_edges(input int m);
    repeat (m) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic kick(input bit release_line);
    wd_n = 1'b0;
    repeat (3) @(negedge clk);
    if (release_line) wd_n = 1'b1;
  endtask

  task automatic set_sel(input logic [1:0] s);
    tmo_sel = s;
    wait_edges(2);
  endtask

  initial begin
    #750000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 reset state");

    tmo_sel = 2'b00;
    wait_edges(800);
    check(1'b0, "R3 select 00 disables");

    serial_mode = 1'b0; tmo_sel = 2'b01;
    wait_edges(300);
    check(1'b0, "R2 parallel mode never trips");
    serial_mode = 1'b1;

    for (int s = 1; s <= 3; s++) begin
      set_sel(2'(s));
      kick(1'b1);
      wait_edges(window_cycles(2'(s)) - 1);
      check(1'b0, "R4 one cycle before expiry");
      wait_edges(1);
      check(1'b1, "R4 expiry cycle");
      wait_edges(20);
      check(1'b1, "R7 trip persists");
      kick(1'b1);
      check(1'b0, "R7 kick releases");
    end

    set_sel(2'b01);
    kick(1'b0);
    wait_edges(window_cycles(2'b01) - 1);
    check(1'b0, "R6 held low before expiry");
    wait_edges(1);
    check(1'b1, "R6 held low still expires");
    wd_n = 1'b1;
    wait_edges(5);
    check(1'b1, "R6 rising edge no release");
    kick(1'b1);
    check(1'b0, "R7 release after hold");

    kick(1'b1);
    wait_edges(100);
    tmo_sel = 2'b10;
    wait_edges(window_cycles(2'b10));
    check(1'b0, "R8 restart on select change");
    wait_edges(1);
    check(1'b1, "R8 new window expiry");
    kick(1'b1);

    set_sel(2'b01);
    kick(1'b1);
    wait_edges(window_cycles(2'b01));
    check(1'b1, "R2 trip before mode drop");
    serial_mode = 1'b0;
    wait_edges(1);
    check(1'b0, "R2 mode drop clears trip");
    serial_mode = 1'b1;

    for (int i = 0; i < 25; i++) begin
      logic [1:0] s;
      s = 2'($urandom_range(1, 3));
      set_sel(s);
      kick(1'b1);
      for (int j = 0; j < 3; j++) begin
        int r;
        r = $urandom % (window_cycles(s) - 4);
        wait_edges(r);
        check(1'b0, "R5 periodic kicks keep alive");
        kick(1'b1);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule